// File: doc/BRIEF.md
# Masked Sequential Reset Sequencer

This block drives the internal reset lines of one direction of a serial transceiver. After a master reset is released and the PLL reports lock, it asserts a chosen set of sub-block resets and then raises a completion flag. The set of stages used comes from two enable masks, one for the analog-side (PMA) group and one for the coding-side (PCS) group. Each stage carries its own 5-bit hold time in clock cycles.

A mode input selects between two ways of running. In chained mode the enabled stages run one after another in a fixed order. In simultaneous mode all enabled stages start in the same cycle and each one is released when its own time runs out. Separate one-cycle request inputs fire an isolated reset of any single stage, whatever the mode and masks say. The master reset, lock and user-ready inputs pass through a two-flop synchronizer. The request inputs and the configuration inputs are synchronous to the clock.

Stage slots are numbered 0 to 10. Slots 0 to 6 are PMA mask bits 0 to 6, and slots 7 to 10 are PCS mask bits 0 to 3. PMA slots 2 and 3 are reserved and have no reset line behind them.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While the synchronized master reset is high the controller stays idle and starts no stage. After its release (2 synchronizer cycles), the controller leaves idle and moves on to checking lock.
- R2: No masked stage is started until the synchronized PLL-lock input is high. With lock low, all reset outputs and done stay 0 indefinitely.
- R3: In chained mode (`seq_mode_i`=1), the enabled stages are asserted one at a time in ascending slot order: PMA bits 0, 1, 4, 5, 6, then PCS bits 0, 1, 2, 3. Each stage starts only after the previous one is released.
- R4: In simultaneous mode (`seq_mode_i`=0), every enabled stage's reset rises in the same clock cycle.
- R5: The duration field of slot i is `dur_i[5*i+4:5*i]`. A started stage holds its reset for exactly that many cycles, for any value from 1 to 31. The field must be non-zero whenever the stage is enabled.
- R6: Mask mapping: PMA bit 0 is the PMA top, bit 1 the ADC clock generator, bit 4 adaptation, bit 5 CDR phase and bit 6 CDR frequency. PCS bit 0 is eye scan, bit 1 FEC, bit 2 PCS top and bit 3 the PRBS counter. PMA bits 2 and 3 never assert, and disabled stages never assert during a sequence.
- R7: A PCS stage started by the sequence is not released while synchronized user-ready is low, even after its time has run out.
- R8: `done_o` is 0 out of reset and falls within 3 cycles of the master reset rising. It rises only after every sequence-started reset has been released, and then stays high until the next master reset.
- R9: A one-cycle pulse on `solo_req_i[i]` resets slot i alone for its duration. It ignores mode, masks and user-ready, and leaves `done_o` unchanged.
- R10: A master reset during a sequence drops all reset lines at once. After release, the sequence starts again from the first enabled stage.
- R11: With no enabled stage, `done_o` rises after lock without any reset line pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_rst_i | input | 1 | Master reset request, asynchronous, active high |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| user_rdy_i | input | 1 | User logic ready, asynchronous |
| seq_mode_i | input | 1 | 1 = chained, 0 = simultaneous |
| pma_mask_i | input | 7 | PMA stage enables |
| pcs_mask_i | input | 4 | PCS stage enables |
| dur_i | input | 55 | Eleven 5-bit hold times, slot i at bits 5i+4..5i |
| solo_req_i | input | 11 | Isolated single-stage reset requests, one per slot |
| pma_rst_o | output | 7 | PMA sub-block reset lines |
| pcs_rst_o | output | 4 | PCS sub-block reset lines |
| done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with its defaults: 7 PMA slots, of which 2 and 3 are reserved, 4 PCS slots, 5-bit durations and a two-stage synchronizer. With these values every slot, both reserved positions and the duration extremes of 1 and 31 cycles can be reached in short runs. A scoreboard predicts the order and width of each reset pulse. Chained mode orders pulses by slot. Simultaneous mode orders them by duration and then by slot. Directed checks cover lock gating, user-ready holding, aborts in mid-sequence and isolated requests.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCKW,
    ST_SCAN,
    ST_HOLD,
    ST_FIRE,
    ST_HOLD_ALL,
    ST_FIN
  } seq_state_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/rst_seq_cell.sv
module rst_seq_cell #(
  parameter int DUR_W = 5,
  parameter bit GATED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             seq_go,
  input  logic             solo_go,
  input  logic             rdy,
  input  logic [DUR_W-1:0] dur,
  output logic             act_o,
  output logic             own_o
);

  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             own_q, own_d;
  logic             cnt_en;
  logic             load;
  logic             last;
  logic             may_end;

  assign load    = seq_go | solo_go;
  assign last    = act_q && (cnt_q == DUR_W'(1));
  assign may_end = !(GATED && own_q) || rdy;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    act_d  = act_q;
    own_d  = own_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      act_d  = 1'b0;
      own_d  = 1'b0;
    end else if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (dur == '0) ? DUR_W'(1) : dur;
      act_d  = 1'b1;
      own_d  = seq_go;
    end else if (last) begin
      if (may_end) begin
        act_d = 1'b0;
        own_d = 1'b0;
      end
    end else if (act_q) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      act_q <= act_d;
      own_q <= own_d;
    end
  end

  assign act_o = act_q;
  assign own_o = own_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int               PMA_W     = 7,
  parameter int               PCS_W     = 4,
  parameter int               DUR_W     = 5,
  parameter int               SYNC_N    = 2,
  parameter logic [PMA_W-1:0] PMA_VALID = 7'b1110011
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mst_rst_i,
  input  logic                           pll_lock_i,
  input  logic                           user_rdy_i,
  input  logic                           seq_mode_i,
  input  logic [PMA_W-1:0]               pma_mask_i,
  input  logic [PCS_W-1:0]               pcs_mask_i,
  input  logic [(PMA_W+PCS_W)*DUR_W-1:0] dur_i,
  input  logic [PMA_W+PCS_W-1:0]         solo_req_i,
  output logic [PMA_W-1:0]               pma_rst_o,
  output logic [PCS_W-1:0]               pcs_rst_o,
  output logic                           done_o
);

  localparam int NSTG = PMA_W + PCS_W;
  localparam int IDXW = $clog2(NSTG + 1);
  localparam logic [NSTG-1:0] LIVE_MASK = {{PCS_W{1'b1}}, PMA_VALID};

  logic             mst_s, lock_s, rdy_s;
  seq_state_t       st_q, st_d;
  logic [IDXW-1:0]  idx_q, idx_d;
  logic [IDXW-1:0]  nxt_idx;
  logic             nxt_found;
  logic             mode_q, mode_d;
  logic             done_q;
  logic [NSTG-1:0]  eff_mask;
  logic [NSTG-1:0]  seq_go;
  logic [NSTG-1:0]  act;
  logic [NSTG-1:0]  own;

  rst_seq_sync #(
    .W       (3),
    .STAGES  (SYNC_N),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({user_rdy_i, pll_lock_i, mst_rst_i}),
    .q     ({rdy_s, lock_s, mst_s})
  );

  assign eff_mask = {pcs_mask_i, pma_mask_i} & LIVE_MASK;

  // lowest enabled slot at or above the current pointer
  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (eff_mask[i] && (i >= int'(idx_q))) begin
        nxt_found = 1'b1;
        nxt_idx   = IDXW'(i);
      end
    end
  end

  always_comb begin
    seq_go = '0;
    if (!mst_s) begin
      if (st_q == ST_SCAN && nxt_found) seq_go[nxt_idx] = 1'b1;
      if (st_q == ST_FIRE)              seq_go = eff_mask;
    end
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    mode_d = mode_q;
    if (mst_s) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_LOCKW;
        ST_LOCKW: begin
          if (lock_s) begin
            mode_d = seq_mode_i;
            idx_d  = '0;
            st_d   = seq_mode_i ? ST_SCAN : ST_FIRE;
          end
        end
        ST_SCAN: begin
          if (nxt_found) begin
            idx_d = nxt_idx;
            st_d  = ST_HOLD;
          end else begin
            st_d = ST_FIN;
          end
        end
        ST_HOLD: begin
          if (!own[idx_q]) begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_SCAN;
          end
        end
        ST_FIRE:     st_d = ST_HOLD_ALL;
        ST_HOLD_ALL: if (own == '0) st_d = ST_FIN;
        ST_FIN:      st_d = ST_FIN;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
      done_q <= (st_d == ST_FIN);
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    if (LIVE_MASK[g]) begin : g_cell
      rst_seq_cell #(
        .DUR_W (DUR_W),
        .GATED (g >= PMA_W)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mst_s),
        .seq_go  (seq_go[g]),
        .solo_go (solo_req_i[g]),
        .rdy     (rdy_s),
        .dur     (dur_i[g*DUR_W +: DUR_W]),
        .act_o   (act[g]),
        .own_o   (own[g])
      );
    end else begin : g_void
      assign act[g] = 1'b0;
      assign own[g] = 1'b0;
    end
  end

  assign pma_rst_o = act[PMA_W-1:0];
  assign pcs_rst_o = act[NSTG-1:PMA_W];
  assign done_o    = done_q;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
  parameter int PMA_W = 7,
  parameter int PCS_W = 4,
  parameter int DUR_W = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           mst_s,
  input logic                           rdy_s,
  input logic                           mode_q,
  input logic [PMA_W+PCS_W-1:0]         own,
  input logic [PMA_W+PCS_W-1:0]         act,
  input logic [PMA_W+PCS_W-1:0]         seq_go,
  input logic [(PMA_W+PCS_W)*DUR_W-1:0] dur_i,
  input logic                           done_o
);

  localparam int NSTG = PMA_W + PCS_W;

  logic [NSTG-1:0] zdur;
  for (genvar g = 0; g < NSTG; g++) begin : g_z
    assign zdur[g] = (dur_i[g*DUR_W +: DUR_W] == '0);
  end

  AST_CHAIN_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> $onehot0(own)); // R3

  AST_NONZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(seq_go & zdur))); // R5

  AST_PCS_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|($past(own[NSTG-1:PMA_W]) & ~act[NSTG-1:PMA_W])) && !$past(mst_s))
      |-> $past(rdy_s)); // R7

  AST_DONE_FALLS_ON_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    mst_s |=> !done_o); // R8

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (own == '0)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mst_s) |=> done_o); // R8

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
  .PMA_W (PMA_W),
  .PCS_W (PCS_W),
  .DUR_W (DUR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mst_s  (mst_s),
  .rdy_s  (rdy_s),
  .mode_q (mode_q),
  .own    (own),
  .act    (act),
  .seq_go (seq_go),
  .dur_i  (dur_i),
  .done_o (done_o)
);

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;

  localparam int NS = 11;
  localparam logic [NS-1:0] LIVE = 11'b11111110011; // R6: PMA bits 2,3 reserved

  logic        clk;
  logic        rst_n;
  logic        mst_rst_i, pll_lock_i, user_rdy_i, seq_mode_i;
  logic [6:0]  pma_mask_i;
  logic [3:0]  pcs_mask_i;
  logic [54:0] dur_i;
  logic [10:0] solo_req_i;
  logic [6:0]  pma_rst_o;
  logic [3:0]  pcs_rst_o;
  logic        done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit sb_on = 1'b0;
  bit ended = 1'b0;
  int exp_idx[$];
  int exp_len[$];

  rst_seq_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mst_rst_i  (mst_rst_i),
    .pll_lock_i (pll_lock_i),
    .user_rdy_i (user_rdy_i),
    .seq_mode_i (seq_mode_i),
    .pma_mask_i (pma_mask_i),
    .pcs_mask_i (pcs_mask_i),
    .dur_i      (dur_i),
    .solo_req_i (solo_req_i),
    .pma_rst_o  (pma_rst_o),
    .pcs_rst_o  (pcs_rst_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int dur_of(input int i);
    return int'(dur_i[i*5 +: 5]);
  endfunction

  function automatic logic [NS-1:0] outs();
    return {pcs_rst_o, pma_rst_o};
  endfunction

  // scoreboard monitor: one compare per falling reset line
  int run_len [NS];
  logic [NS-1:0] prev;
  initial prev = '0;
  always @(negedge clk) begin
    logic [NS-1:0] cur;
    cur = outs();
    for (int i = 0; i < NS; i++) begin
      if (!sb_on) run_len[i] = 0;
      else if (cur[i]) run_len[i]++;
      else if (prev[i]) begin
        if (exp_idx.size() == 0) begin
          chk(1'b0, "R6 unexpected pulse", i, -1);
        end else begin
          int ei, el;
          ei = exp_idx.pop_front();
          el = exp_len.pop_front();
          chk(ei == i, "R3 pulse order", i, ei);
          if (el != 0) chk(el == run_len[i], "R5 pulse width", run_len[i], el);
        end
        run_len[i] = 0;
      end else run_len[i] = 0;
    end
    prev = cur;
  end

  task automatic push_chain();
    logic [NS-1:0] m;
    m = {pcs_mask_i, pma_mask_i} & LIVE;
    for (int i = 0; i < NS; i++)
      if (m[i]) begin exp_idx.push_back(i); exp_len.push_back(dur_of(i)); end
  endtask

  task automatic push_together();
    logic [NS-1:0] m;
    m = {pcs_mask_i, pma_mask_i} & LIVE;
    for (int d = 1; d < 32; d++)
      for (int i = 0; i < NS; i++)
        if (m[i] && dur_of(i) == d) begin exp_idx.push_back(i); exp_len.push_back(d); end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk(done_o == 1'b1, req, int'(done_o), 1);
  endtask

  task automatic master_pulse();
    mst_rst_i = 1'b1;
    cyc(5);
    chk(done_o == 1'b0, "R8 done low after master", int'(done_o), 0);
    mst_rst_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mst_rst_i = 1'b1; pll_lock_i = 1'b0; user_rdy_i = 1'b1;
    seq_mode_i = 1'b1; pma_mask_i = 7'h7F; pcs_mask_i = 4'hF; solo_req_i = '0;
    for (int i = 0; i < NS; i++) dur_i[i*5 +: 5] = 5'(3 + i);
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    chk(outs() == '0, "R1 reset state lines", int'(outs()), 0);
    chk(done_o == 1'b0, "R8 reset state done", int'(done_o), 0);
    sb_on = 1'b1;

    // R2: no start without lock
    mst_rst_i = 1'b0;
    cyc(20);
    chk(outs() == '0, "R2 idle without lock", int'(outs()), 0);
    chk(done_o == 1'b0, "R2 done without lock", int'(done_o), 0);
    push_chain();
    pll_lock_i = 1'b1;
    cyc(12);
    chk(done_o == 1'b0, "R8 done low while busy", int'(done_o), 0);
    wait_done("R3 chained full done");
    chk(exp_idx.size() == 0, "R3 chained all seen", exp_idx.size(), 0);

    // R4: simultaneous mode, ordered release by duration
    seq_mode_i = 1'b0; pma_mask_i = 7'b0110001; pcs_mask_i = 4'b0101;
    dur_i[0*5 +: 5] = 9; dur_i[4*5 +: 5] = 2; dur_i[5*5 +: 5] = 5;
    dur_i[7*5 +: 5] = 4; dur_i[9*5 +: 5] = 2;
    push_together();
    master_pulse();
    begin
      int n;
      n = 0;
      while (outs() == '0 && n < 100) begin @(negedge clk); n++; end
    end
    chk(outs() == 11'b01010110001, "R4 all rise together", int'(outs()), 11'b01010110001);
    wait_done("R4 simultaneous done");
    chk(exp_idx.size() == 0, "R4 all released", exp_idx.size(), 0);

    // R5: duration extremes in chained mode
    seq_mode_i = 1'b1; pma_mask_i = 7'b1000010; pcs_mask_i = 4'b1000;
    dur_i[1*5 +: 5] = 1; dur_i[6*5 +: 5] = 31; dur_i[10*5 +: 5] = 1;
    push_chain();
    master_pulse();
    wait_done("R5 extremes done");
    chk(exp_idx.size() == 0, "R5 extremes seen", exp_idx.size(), 0);

    // R6 / R11: only reserved bits enabled
    pma_mask_i = 7'b0001100; pcs_mask_i = 4'b0000;
    master_pulse();
    wait_done("R11 empty mask done");
    chk(outs() == '0, "R6 reserved quiet", int'(outs()), 0);

    // R7: PCS stage held until user ready
    seq_mode_i = 1'b0; pma_mask_i = 7'b0; pcs_mask_i = 4'b0010;
    dur_i[8*5 +: 5] = 4;
    user_rdy_i = 1'b0;
    exp_idx.push_back(8); exp_len.push_back(0);
    master_pulse();
    begin
      int n;
      n = 0;
      while (outs() == '0 && n < 100) begin @(negedge clk); n++; end
    end
    cyc(10);
    chk(pcs_rst_o[1] == 1'b1, "R7 held without ready", int'(pcs_rst_o[1]), 1);
    chk(done_o == 1'b0, "R7 done waits", int'(done_o), 0);
    user_rdy_i = 1'b1;
    wait_done("R7 release after ready");
    chk(exp_idx.size() == 0, "R7 pulse seen", exp_idx.size(), 0);

    // R9: isolated requests, reserved request ignored, no ready wait
    user_rdy_i = 1'b0;
    dur_i[5*5 +: 5] = 3; dur_i[9*5 +: 5] = 6;
    exp_idx.push_back(5); exp_len.push_back(3);
    exp_idx.push_back(9); exp_len.push_back(6);
    solo_req_i = 11'b01000100100;
    cyc(1);
    solo_req_i = '0;
    cyc(15);
    chk(exp_idx.size() == 0, "R9 solo pulses seen", exp_idx.size(), 0);
    chk(done_o == 1'b1, "R9 done untouched", int'(done_o), 1);
    user_rdy_i = 1'b1;

    // R10: abort mid-sequence, then full restart
    seq_mode_i = 1'b1; pma_mask_i = 7'h7F; pcs_mask_i = 4'hF;
    for (int i = 0; i < NS; i++) dur_i[i*5 +: 5] = 5'(3 + i);
    sb_on = 1'b0;
    master_pulse();
    cyc(20);
    chk(outs() != '0, "R10 busy before abort", int'(outs()), 1);
    mst_rst_i = 1'b1;
    cyc(4);
    chk(outs() == '0, "R10 lines drop", int'(outs()), 0);
    chk(done_o == 1'b0, "R10 done low", int'(done_o), 0);
    exp_idx.delete(); exp_len.delete();
    sb_on = 1'b1;
    push_chain();
    mst_rst_i = 1'b0;
    wait_done("R10 restart done");
    chk(exp_idx.size() == 0, "R10 restart from first", exp_idx.size(), 0);

    cyc(3);
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule